// File: doc/BRIEF.md
# Local-Structure Minutia Pair Matcher

This block decides whether one minutia from a freshly captured fingerprint and one minutia from a stored template describe the same point. Each minutia arrives as a neighbourhood descriptor: its own ridge direction and, for each of six nearest neighbours, a distance, a radial angle and a position angle. No global alignment is attempted. The two ridge directions must first agree within a tolerance. After that, the block walks the input neighbours one at a time. Each input neighbour claims at most one template neighbour that lies inside a three-axis tolerance box, and the pair counts as matched when enough neighbours were claimed.

Software loads four tolerances and the two minutia counts through a small write port, then streams descriptor pairs in over a valid/ready handshake. Each accepted pair yields one result cycle. A running count of matched pairs is kept, and the larger of the two minutia counts is presented beside it, so the caller can divide the two to form the final similarity score.

Top module: `minutia_pair_matcher`

## Requirements
- R1: After reset, in_ready is 1, res_valid is 0, pair_count is 0, max_count is 0 and every tolerance is 0.
- R2: A descriptor pair is taken on a rising edge where in_valid and in_ready are both 1. in_ready stays 0 from the following cycle until the result cycle has passed. A descriptor packs the direction in bits [5:0] and neighbour k at base 6+21k: distance [base+8:base], radial angle [base+14:base+9], position angle [base+20:base+15].
- R3: If the circular direction difference exceeds the direction tolerance, the result (res_valid=1, res_match=0, res_marks=0) appears in the first cycle after acceptance and no neighbour is examined.
- R4: An input/template neighbour pair lies in the box when |distance difference| ≤ distance tolerance and both circular angle differences are within their tolerances. All bounds are inclusive. Angles are compared modulo 32 as min(x, 32−x), so an angle code of 32 equals 0.
- R5: Input neighbours are visited in index order 0..5. Each claims the lowest-index template neighbour that is in its box and not yet claimed in this comparison, so each template neighbour is claimed at most once.
- R6: When the direction gate passes, the result appears 7 cycles after acceptance, with res_marks equal to the number of claims and res_match = 1 exactly when res_marks ≥ 3.
- R7: pair_count rises by exactly 1 in the cycle after each result with res_match=1 and is otherwise unchanged.
- R8: max_count equals the larger of the input and template minutia counts. Writing either count clears pair_count.
- R9: Configuration writes made while in_ready is 0 are discarded.
- R10: Write addresses: 0 direction tolerance, 1 distance tolerance, 2 radial tolerance, 3 position tolerance, 4 input minutia count, 5 template minutia count. Addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 9 | Configuration write value |
| in_valid | input | 1 | Descriptor pair offered |
| in_ready | output | 1 | Block idle and able to take a pair |
| in_desc | input | 132 | Input minutia descriptor |
| tpl_desc | input | 132 | Template minutia descriptor |
| res_valid | output | 1 | Result cycle |
| res_match | output | 1 | Pair declared matched |
| res_marks | output | 3 | Number of claimed neighbour pairs |
| pair_count | output | 16 | Accumulated matched-pair count |
| max_count | output | 8 | Larger of the two minutia counts |

## Verification
The corner cases targeted are the inclusive edges of every tolerance (distance off by exactly the tolerance and by one more), angle wrap-around between codes 31 and 1 and between 32 and 0, and a direction gate that must reject early. A design with a strict comparison or a plain subtraction would drop or add claims there, and an early-reject path that still scans would show the wrong latency. A template neighbour that fits every input neighbour exposes a missing claim mask, which would report six claims instead of one. Threshold edges at two and three claims, a configuration write during a scan, and count writes that must clear the accumulator complete the set. Seeded sweeps compared against an arithmetic model in the bench cover the rest.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

  localparam int ANG_BITS = 5;
  localparam int AW       = ANG_BITS + 1;
  localparam int ANG_MOD  = 1 << ANG_BITS;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } mpm_state_e;

  // shorter way round the circle of ANG_MOD codes
  function automatic logic [AW-1:0] ang_dist(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    logic [ANG_BITS-1:0] d;
    d = a[ANG_BITS-1:0] - b[ANG_BITS-1:0];
    if (d[ANG_BITS-1]) return AW'(ANG_MOD) - {1'b0, d};
    else               return {1'b0, d};
  endfunction

endpackage

// File: rtl/mpm_cfg.sv
module mpm_cfg
  import mpm_pkg::*;
#(
  parameter int DW = 9,
  parameter int CW = 8,
  parameter int WW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [WW-1:0] wdata,
  output logic [AW-1:0] tol_dir,
  output logic [DW-1:0] tol_dist,
  output logic [AW-1:0] tol_rad,
  output logic [AW-1:0] tol_pos,
  output logic [CW-1:0] cnt_in,
  output logic [CW-1:0] cnt_tpl,
  output logic          cnt_wr
);

  logic [7:0] sel;

  always_comb begin
    sel = '0;
    if (we) sel[addr] = 1'b1;
  end

  assign cnt_wr = sel[4] | sel[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tol_dir  <= '0;
      tol_dist <= '0;
      tol_rad  <= '0;
      tol_pos  <= '0;
      cnt_in   <= '0;
      cnt_tpl  <= '0;
    end else begin
      if (sel[0]) tol_dir  <= wdata[AW-1:0];
      if (sel[1]) tol_dist <= wdata[DW-1:0];
      if (sel[2]) tol_rad  <= wdata[AW-1:0];
      if (sel[3]) tol_pos  <= wdata[AW-1:0];
      if (sel[4]) cnt_in   <= wdata[CW-1:0];
      if (sel[5]) cnt_tpl  <= wdata[CW-1:0];
    end
  end

endmodule

// File: rtl/mpm_nb_box.sv
module mpm_nb_box
  import mpm_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic [DW-1:0] a_dist,
  input  logic [AW-1:0] a_rad,
  input  logic [AW-1:0] a_pos,
  input  logic [DW-1:0] b_dist,
  input  logic [AW-1:0] b_rad,
  input  logic [AW-1:0] b_pos,
  input  logic [DW-1:0] tol_dist,
  input  logic [AW-1:0] tol_rad,
  input  logic [AW-1:0] tol_pos,
  output logic          hit
);

  logic [DW-1:0] dd;
  logic [AW-1:0] dr;
  logic [AW-1:0] dp;

  always_comb begin
    dd  = (a_dist >= b_dist) ? (a_dist - b_dist) : (b_dist - a_dist);
    dr  = ang_dist(a_rad, b_rad);
    dp  = ang_dist(a_pos, b_pos);
    hit = (dd <= tol_dist) && (dr <= tol_rad) && (dp <= tol_pos);
  end

endmodule

// File: rtl/mpm_pick.sv
module mpm_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] grant,
  output logic         any
);

  // isolate lowest set bit
  assign grant = cand & (~cand + N'(1));
  assign any   = |cand;

endmodule

// File: rtl/minutia_pair_matcher.sv
module minutia_pair_matcher
  import mpm_pkg::*;
#(
  parameter int NNB      = 6,
  parameter int DW       = 9,
  parameter int CW       = 8,
  parameter int BW       = 16,
  parameter int MATCH_TH = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [2:0]                        cfg_addr,
  input  logic [((DW > CW) ? DW : CW)-1:0]  cfg_wdata,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [AW + NNB*(DW+2*AW)-1:0]     in_desc,
  input  logic [AW + NNB*(DW+2*AW)-1:0]     tpl_desc,
  output logic                              res_valid,
  output logic                              res_match,
  output logic [$clog2(NNB+1)-1:0]          res_marks,
  output logic [BW-1:0]                     pair_count,
  output logic [CW-1:0]                     max_count
);

  localparam int WW     = (DW > CW) ? DW : CW;
  localparam int NBW    = DW + 2*AW;
  localparam int DESC_W = AW + NNB*NBW;
  localparam int IW     = (NNB > 1) ? $clog2(NNB) : 1;
  localparam int MW     = $clog2(NNB+1);

  // configuration
  logic [AW-1:0] tol_dir, tol_rad, tol_pos;
  logic [DW-1:0] tol_dist;
  logic [CW-1:0] cnt_in, cnt_tpl;
  logic          cnt_wr;
  logic          idle;

  assign idle = (st_q == ST_IDLE);

  mpm_cfg #(.DW(DW), .CW(CW), .WW(WW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we & idle),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .tol_dir  (tol_dir),
    .tol_dist (tol_dist),
    .tol_rad  (tol_rad),
    .tol_pos  (tol_pos),
    .cnt_in   (cnt_in),
    .cnt_tpl  (cnt_tpl),
    .cnt_wr   (cnt_wr)
  );

  // state
  mpm_state_e        st_q, st_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [NNB-1:0]    used_q, used_d;
  logic [MW-1:0]     marks_q, marks_d;
  logic              gate_q, gate_d;
  logic [BW-1:0]     pair_q, pair_d;
  logic [DESC_W-1:0] in_q, tpl_q;
  logic              ld_en;

  // descriptor fields
  logic [DW-1:0] in_dist  [NNB];
  logic [AW-1:0] in_rad   [NNB];
  logic [AW-1:0] in_pos   [NNB];
  logic [DW-1:0] tp_dist  [NNB];
  logic [AW-1:0] tp_rad   [NNB];
  logic [AW-1:0] tp_pos   [NNB];
  logic [NNB-1:0] hit_vec, cand, grant;
  logic           grant_any;
  logic           dir_ok;

  genvar k;
  generate
    for (k = 0; k < NNB; k++) begin : g_nb
      assign in_dist[k] = in_q [AW + k*NBW          +: DW];
      assign in_rad[k]  = in_q [AW + k*NBW + DW     +: AW];
      assign in_pos[k]  = in_q [AW + k*NBW + DW + AW +: AW];
      assign tp_dist[k] = tpl_q[AW + k*NBW          +: DW];
      assign tp_rad[k]  = tpl_q[AW + k*NBW + DW     +: AW];
      assign tp_pos[k]  = tpl_q[AW + k*NBW + DW + AW +: AW];

      mpm_nb_box #(.DW(DW)) u_box (
        .a_dist   (in_dist[idx_q]),
        .a_rad    (in_rad[idx_q]),
        .a_pos    (in_pos[idx_q]),
        .b_dist   (tp_dist[k]),
        .b_rad    (tp_rad[k]),
        .b_pos    (tp_pos[k]),
        .tol_dist (tol_dist),
        .tol_rad  (tol_rad),
        .tol_pos  (tol_pos),
        .hit      (hit_vec[k])
      );
    end
  endgenerate

  assign cand = hit_vec & ~used_q;

  mpm_pick #(.N(NNB)) u_pick (
    .cand  (cand),
    .grant (grant),
    .any   (grant_any)
  );

  assign dir_ok = (ang_dist(in_desc[AW-1:0], tpl_desc[AW-1:0]) <= tol_dir);

  // outputs
  assign in_ready   = idle;
  assign res_valid  = (st_q == ST_FIN);
  assign res_match  = res_valid && gate_q && (marks_q >= MW'(MATCH_TH));
  assign res_marks  = marks_q;
  assign pair_count = pair_q;
  assign max_count  = (cnt_in >= cnt_tpl) ? cnt_in : cnt_tpl;

  // next state
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    used_d  = used_q;
    marks_d = marks_q;
    gate_d  = gate_q;
    pair_d  = pair_q;
    ld_en   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (in_valid) begin
          ld_en   = 1'b1;
          idx_d   = '0;
          used_d  = '0;
          marks_d = '0;
          gate_d  = dir_ok;
          st_d    = dir_ok ? ST_SCAN : ST_FIN;
        end
      end
      ST_SCAN: begin
        if (grant_any) begin
          used_d  = used_q | grant;
          marks_d = marks_q + 1'b1;
        end
        if (idx_q == IW'(NNB-1)) st_d = ST_FIN;
        else                     idx_d = idx_q + 1'b1;
      end
      ST_FIN: begin
        st_d = ST_IDLE;
        if (res_match) pair_d = pair_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (cnt_wr) pair_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      used_q  <= '0;
      marks_q <= '0;
      gate_q  <= 1'b0;
      pair_q  <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      used_q  <= used_d;
      marks_q <= marks_d;
      gate_q  <= gate_d;
      pair_q  <= pair_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      tpl_q <= '0;
    end else if (ld_en) begin
      in_q  <= in_desc;
      tpl_q <= tpl_desc;
    end
  end

  // assertions
  AST_READY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !res_valid);  // R2
  AST_REJECT_NO_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !gate_q) |-> (res_marks == '0));  // R3
  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN) |-> ($onehot0(grant) && ((grant & used_q) == '0)));  // R5
  AST_MARKS_MATCH_USED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(used_q) == int'(marks_q)));  // R5
  AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && idx_q == IW'(NNB-1)) |=> res_valid);  // R6
  AST_B_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_match) |=> (pair_q == BW'($past(pair_q) + 1'b1)));  // R7
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !cnt_wr) |=> $stable(pair_q));  // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(tol_dist) && $stable(tol_dir)));  // R9

endmodule

// File: tb/minutia_pair_matcher_bench.sv
module minutia_pair_matcher_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NNB    = 6;
  localparam int DW     = 9;
  localparam int AW     = 6;
  localparam int CW     = 8;
  localparam int BW     = 16;
  localparam int NBW    = DW + 2*AW;
  localparam int DESC_W = AW + NNB*NBW;

  logic              clk;
  logic              rst_n;
  logic              cfg_we;
  logic [2:0]        cfg_addr;
  logic [8:0]        cfg_wdata;
  logic              in_valid;
  logic              in_ready;
  logic [DESC_W-1:0] in_desc;
  logic [DESC_W-1:0] tpl_desc;
  logic              res_valid;
  logic              res_match;
  logic [2:0]        res_marks;
  logic [BW-1:0]     pair_count;
  logic [CW-1:0]     max_count;

  minutia_pair_matcher u_minutia_pair_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_desc(in_desc), .tpl_desc(tpl_desc), .res_valid(res_valid),
    .res_match(res_match), .res_marks(res_marks),
    .pair_count(pair_count), .max_count(max_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  int m_tdir, m_tdist, m_trad, m_tpos, m_cin, m_ctpl, m_b;

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cdist(int a, int b);
    int d;
    d = (a - b) & 31;
    return (d > 16) ? 32 - d : d;
  endfunction

  function automatic int f_dist(logic [DESC_W-1:0] v, int k);
    return int'(v[AW + k*NBW +: DW]);
  endfunction
  function automatic int f_rad(logic [DESC_W-1:0] v, int k);
    return int'(v[AW + k*NBW + DW +: AW]);
  endfunction
  function automatic int f_pos(logic [DESC_W-1:0] v, int k);
    return int'(v[AW + k*NBW + DW + AW +: AW]);
  endfunction

  // -1 means rejected by the direction gate
  function automatic int ref_marks(logic [DESC_W-1:0] a, logic [DESC_W-1:0] b);
    bit taken [NNB];
    int n, dd;
    if (cdist(int'(a[AW-1:0]), int'(b[AW-1:0])) > m_tdir) return -1;
    n = 0;
    for (int j = 0; j < NNB; j++) taken[j] = 0;
    for (int i = 0; i < NNB; i++) begin
      for (int j = 0; j < NNB; j++) begin
        dd = f_dist(a, i) - f_dist(b, j);
        if (dd < 0) dd = -dd;
        if (!taken[j] && dd <= m_tdist &&
            cdist(f_rad(a, i), f_rad(b, j)) <= m_trad &&
            cdist(f_pos(a, i), f_pos(b, j)) <= m_tpos) begin
          taken[j] = 1;
          n++;
          break;
        end
      end
    end
    return n;
  endfunction

  function automatic logic [DESC_W-1:0] put_nb(logic [DESC_W-1:0] v, int k,
                                               int d, int r, int p);
    v[AW + k*NBW +: DW]           = DW'(d);
    v[AW + k*NBW + DW +: AW]      = AW'(r);
    v[AW + k*NBW + DW + AW +: AW] = AW'(p);
    return v;
  endfunction

  function automatic logic [DESC_W-1:0] put_dir(logic [DESC_W-1:0] v, int d);
    v[AW-1:0] = AW'(d);
    return v;
  endfunction

  function automatic logic [DESC_W-1:0] base_desc();
    logic [DESC_W-1:0] v;
    v = '0;
    v = put_dir(v, 10);
    for (int k = 0; k < NNB; k++) v = put_nb(v, k, 20 + 30*k, 4*k, 31 - 4*k);
    return v;
  endfunction

  task automatic cfg_wr(int addr, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 9'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      0: m_tdir  = val & 63;
      1: m_tdist = val;
      2: m_trad  = val & 63;
      3: m_tpos  = val & 63;
      4: begin m_cin  = val & 255; m_b = 0; end
      5: begin m_ctpl = val & 255; m_b = 0; end
      default: ;
    endcase
  endtask

  // poke: attempt a distance-tolerance write of 0 during the scan (R9)
  task automatic run_cmp(logic [DESC_W-1:0] a, logic [DESC_W-1:0] b,
                         string tag, bit poke);
    int e, lat, exp_lat, exp_m;
    e = ref_marks(a, b);
    @(negedge clk);
    check({tag, " R2 ready before launch"}, int'(in_ready), 1);
    in_desc = a; tpl_desc = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (e >= 0) check({tag, " R2 busy during scan"}, int'(in_ready), 0);
    if (poke) begin cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 9'd0; end
    lat = 1;
    while (!res_valid && lat < 20) begin
      @(negedge clk);
      cfg_we = 1'b0;
      lat++;
    end
    cfg_we = 1'b0;
    exp_lat = (e < 0) ? 1 : NNB + 1;
    exp_m   = (e >= 3) ? 1 : 0;
    check({tag, (e < 0) ? " R3 latency" : " R6 latency"}, lat, exp_lat);
    check({tag, " R5 claimed neighbours"}, int'(res_marks), (e < 0) ? 0 : e);
    check({tag, " R6 match flag"}, int'(res_match), exp_m);
    m_b += exp_m;
    @(negedge clk);
    check({tag, " R7 pair count"}, int'(pair_count), m_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [DESC_W-1:0] a, b;
    int dr, sh;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_desc = '0; tpl_desc = '0;
    m_tdir = 0; m_tdist = 0; m_trad = 0; m_tpos = 0;
    m_cin = 0; m_ctpl = 0; m_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", int'(in_ready), 1);
    check("R1 valid", int'(res_valid), 0);
    check("R1 pair count", int'(pair_count), 0);
    check("R1 max count", int'(max_count), 0);
    // zero tolerances: identical descriptors still match fully
    a = base_desc();
    run_cmp(a, a, "R1 zero tol identical", 0);
    b = put_nb(a, 0, 21, 0, 31);
    run_cmp(a, b, "R1 zero tol off by one", 0);

    // R10 address map, R8 maximum
    cfg_wr(0, 2); cfg_wr(1, 5); cfg_wr(2, 2); cfg_wr(3, 2);
    cfg_wr(4, 10); cfg_wr(5, 7); cfg_wr(6, 1); cfg_wr(7, 200);
    check("R8 max of 10,7", int'(max_count), 10);
    check("R8 cleared", int'(pair_count), 0);

    a = base_desc();
    run_cmp(a, a, "R6 identical", 0);
    run_cmp(put_dir(a, 31), put_dir(a, 1), "R4 dir wrap 31/1", 0);
    run_cmp(put_dir(a, 0), put_dir(a, 3), "R3 dir reject 0/3", 0);
    run_cmp(put_dir(a, 32), put_dir(a, 0), "R4 dir 32 equals 0", 0);
    run_cmp(a, put_nb(a, 0, 25, 0, 31), "R4 dist edge +5", 0);
    run_cmp(a, put_nb(a, 0, 26, 0, 31), "R4 dist edge +6", 0);
    run_cmp(a, put_nb(a, 1, 50, 6, 27), "R4 radial edge +2", 0);
    run_cmp(a, put_nb(a, 1, 50, 7, 27), "R4 radial edge +3", 0);
    run_cmp(put_nb(a, 0, 20, 31, 31), put_nb(a, 0, 20, 1, 31), "R4 radial wrap", 0);
    run_cmp(put_nb(a, 0, 20, 0, 32), put_nb(a, 0, 20, 0, 1), "R4 pos 32 vs 1", 0);
    b = a;
    for (int k = 3; k < NNB; k++) b = put_nb(b, k, 250, 0, 0);
    run_cmp(a, b, "R6 three claims", 0);
    b = put_nb(b, 2, 250, 0, 0);
    run_cmp(a, b, "R6 two claims", 0);
    // one template neighbour fits every input neighbour
    a = put_dir('0, 5);
    b = put_dir('0, 5);
    for (int k = 0; k < NNB; k++) begin
      a = put_nb(a, k, 100, 8, 8);
      b = put_nb(b, k, (k == 0) ? 100 : 0, 8, 8);
    end
    run_cmp(a, b, "R5 single template claim", 0);
    // order: in0 fits tpl0,tpl1; in1 fits only tpl0
    a = put_nb(a, 0, 100, 8, 8); a = put_nb(a, 1, 96, 8, 8);
    b = put_nb(b, 0, 100, 8, 8); b = put_nb(b, 1, 104, 8, 8);
    run_cmp(a, b, "R5 lowest index first", 0);

    // R9 write during scan discarded
    a = base_desc();
    b = a;
    for (int k = 0; k < NNB; k++) b = put_nb(b, k, 23 + 30*k, 4*k, 31 - 4*k);
    run_cmp(a, b, "R9 poke during scan", 1);
    run_cmp(a, b, "R9 tolerance kept", 0);

    // R8 count write clears accumulator
    cfg_wr(4, 3);
    check("R8 cleared by count write", int'(pair_count), 0);
    check("R8 max of 3,7", int'(max_count), 7);
    cfg_wr(5, 200);
    check("R8 max of 3,200", int'(max_count), 200);

    // sweeps with perturbed templates
    for (int ph = 0; ph < 3; ph++) begin
      if (ph == 1) begin cfg_wr(0, 1); cfg_wr(1, 0); cfg_wr(2, 0); cfg_wr(3, 1); end
      if (ph == 2) begin cfg_wr(0, 16); cfg_wr(1, 12); cfg_wr(2, 4); cfg_wr(3, 3); end
      for (int n = 0; n < 150; n++) begin
        a = put_dir('0, $urandom_range(0, 32));
        dr = $urandom_range(0, 4);
        b = put_dir('0, (int'(a[AW-1:0]) + dr) & 31);
        sh = $urandom_range(0, 5);
        for (int k = 0; k < NNB; k++) begin
          a = put_nb(a, k, $urandom_range(90, 130), $urandom_range(0, 32),
                     $urandom_range(0, 32));
        end
        for (int k = 0; k < NNB; k++) begin
          int s;
          s = (k + sh) % NNB;
          b = put_nb(b, k, f_dist(a, s) + $urandom_range(0, 8) - 4,
                     (f_rad(a, s) + $urandom_range(0, 4)) & 31,
                     (f_pos(a, s) + 32 - $urandom_range(0, 3)) & 31);
        end
        run_cmp(a, b, "R5 sweep", 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule